// File: doc/BRIEF.md
# Chained Container DMA Channel

This block moves an endless stream of fixed-size containers between a two-slot hardware container buffer and a ring of containers in memory. One instance serves one direction. An RX instance drains filled hardware slots into memory containers. A TX instance fills empty hardware slots from memory containers. A network interface with N channels therefore uses 2*N instances.

Each memory container has a 64-bit descriptor. The descriptor packs a 64-byte aligned status word address and a 64-byte aligned data buffer address, and both share one 12-bit extension field, so every physical address is 44 bits wide. Hardware and software synchronise only through the status word: zero means empty and any other value means full. Each side sets or clears the word; there is no lock.

For each container the channel checks that the current hardware slot is ready. It then polls the memory status word until that word is in the required state, bursts the container's words, writes the status word with its new value, and flips the hardware slot's flag. It then moves on to the other hardware slot and to the next descriptor in the ring.

Top module: `cdma_channel`

## Requirements
- R1: While reset is active, and directly after it, the channel issues no memory request, raises no slot-flag pulse and raises no event. It starts at hardware slot 0 and ring entry 0.
- R2: For the descriptor `d`, the status byte address is `{d[63:52], d[25:0], 6'b0}` and the buffer byte address is `{d[63:52], d[51:26], 6'b0}`. Container word k is at buffer address + 4*k. Every memory address has its two low bits equal to zero.
- R3: While `run_i` is low and the channel is between containers, it issues no memory request.
- R4: An RX channel starts a container only when `hw_full_i` for its current slot is 1. While the memory status word reads non-zero, it moves no data, leaves the hardware slot full, and polls the word again.
- R5: An RX channel that reads a zero status word copies the CONT_WORDS words of the current slot into the buffer in ascending order. It then writes the value 1 to the status word. It then pulses `hw_clr_o[slot]` for one cycle.
- R6: A TX channel starts a container only when `hw_full_i` for its current slot is 0. When the status word reads non-zero, it copies the CONT_WORDS buffer words into that slot, writes 0 to the status word, and pulses `hw_set_o[slot]` for one cycle.
- R7: A TX channel that reads a zero status word moves no data and leaves the hardware slot empty until a later poll finds the word non-zero.
- R8: The hardware slot used alternates 0, 1, 0, ... from one completed container to the next.
- R9: Descriptor ring entry i sits at `desc_ring_i[64*i+63:64*i]`. The ring index advances by one after each completed container and wraps from RING_DEPTH-1 to 0.
- R10: `event_o` is high for exactly one cycle per completed container, in the same cycle as exactly one slot-flag pulse. At no other time is a slot-flag pulse raised.
- R11: A memory request that is not granted stays asserted, with its address, write enable and write data unchanged, until `mem_gnt_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Allows new containers to start |
| desc_ring_i | input | 64*RING_DEPTH | Container descriptors, entry i in bits [64i+63:64i] |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 44 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| hw_full_i | input | 2 | Full flags of the two hardware slots |
| hw_set_o | output | 2 | One-cycle pulse that marks a slot full (TX) |
| hw_clr_o | output | 2 | One-cycle pulse that marks a slot empty (RX) |
| buf_slot_o | output | 1 | Hardware slot being accessed |
| buf_word_o | output | log2(CONT_WORDS) | Word index within the slot |
| buf_rd_o | output | 1 | Slot read; data is returned one cycle later |
| buf_wr_o | output | 1 | Slot write |
| buf_wdata_o | output | 32 | Slot write data |
| buf_rdata_i | input | 32 | Slot read data |
| event_o | output | 1 | Container completed (RX filled / TX freed) |

## Verification
The hardest situation to reach is a container whose hardware slot is ready while the memory status word is in the wrong state. There the channel must keep polling without moving data or touching the slot flag. The bench creates this by writing a busy status into a ring entry before the channel reaches it. It then checks that the buffer and the slot flag do not change, and releases the entry later. The memory model refuses about a quarter of requests based on a pseudo-random pattern, which exercises the hold-until-granted behaviour. A small ring of three entries with two slots makes the slot sequence and the ring index fall out of step, so that the index wraps while the slot sequence continues.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   localparam int PADDR_W = 44;
   localparam int DESC_W  = 64;
   localparam int EXT_W   = 12;
   localparam int HI_W    = 26;
   localparam int ALIGN_W = 6;

   // field order is fixed by the descriptor layout
   typedef struct packed {
      logic [EXT_W-1:0] ext;
      logic [HI_W-1:0]  buf_hi;
      logic [HI_W-1:0]  stat_hi;
   } cdma_desc_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_POLL,
      ST_PWAIT,
      ST_BRD,
      ST_BCAP,
      ST_MWR,
      ST_MRD,
      ST_MWAIT,
      ST_STAT,
      ST_DONE
   } cdma_state_e;

   function automatic logic [PADDR_W-1:0] stat_paddr(input cdma_desc_t d);
      return {d.ext, d.stat_hi, {ALIGN_W{1'b0}}};
   endfunction

   function automatic logic [PADDR_W-1:0] buf_paddr(input cdma_desc_t d);
      return {d.ext, d.buf_hi, {ALIGN_W{1'b0}}};
   endfunction

endpackage

// File: rtl/cdma_modcnt.sv
module cdma_modcnt #(
   parameter int MOD = 4,
   parameter int W   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] val_o,
   output logic         last_o
);

   initial begin
      if (MOD < 1) $error("cdma_modcnt: MOD must be at least 1");
      if ((1 << W) < MOD) $error("cdma_modcnt: W too small for MOD");
   end

   logic [W-1:0] cnt_q;

   assign last_o = (cnt_q == W'(MOD - 1));
   assign val_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= last_o ? '0 : cnt_q + W'(1);
      end
   end

endmodule

// File: rtl/cdma_desc_sel.sv
module cdma_desc_sel
   import cdma_pkg::*;
#(
   parameter int RING_DEPTH = 4,
   parameter int RIDX_W     = 2
) (
   input  logic [RING_DEPTH*DESC_W-1:0] ring_i,
   input  logic [RIDX_W-1:0]            idx_i,
   output logic [PADDR_W-1:0]           stat_addr_o,
   output logic [PADDR_W-1:0]           buf_addr_o
);

   cdma_desc_t cur;

   always_comb begin
      cur = cdma_desc_t'(ring_i[int'(idx_i)*DESC_W +: DESC_W]);
   end

   assign stat_addr_o = stat_paddr(cur);
   assign buf_addr_o  = buf_paddr(cur);

endmodule

// File: rtl/cdma_channel.sv
module cdma_channel
   import cdma_pkg::*;
#(
   parameter bit IS_RX      = 1'b1,
   parameter int CONT_WORDS = 1024,
   parameter int RING_DEPTH = 4,
   localparam int WIDX_W    = $clog2(CONT_WORDS),
   localparam int RIDX_W    = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         run_i,
   input  logic [RING_DEPTH*64-1:0]     desc_ring_i,
   output logic                         mem_req_o,
   output logic                         mem_we_o,
   output logic [43:0]                  mem_addr_o,
   output logic [31:0]                  mem_wdata_o,
   input  logic                         mem_gnt_i,
   input  logic                         mem_rvalid_i,
   input  logic [31:0]                  mem_rdata_i,
   input  logic [1:0]                   hw_full_i,
   output logic [1:0]                   hw_set_o,
   output logic [1:0]                   hw_clr_o,
   output logic                         buf_slot_o,
   output logic [WIDX_W-1:0]            buf_word_o,
   output logic                         buf_rd_o,
   output logic                         buf_wr_o,
   output logic [31:0]                  buf_wdata_o,
   input  logic [31:0]                  buf_rdata_i,
   output logic                         event_o
);

   initial begin
      if (CONT_WORDS < 2 || (CONT_WORDS & (CONT_WORDS - 1)) != 0)
         $error("cdma_channel: CONT_WORDS must be a power of two, at least 2");
      if (RING_DEPTH < 1)
         $error("cdma_channel: RING_DEPTH must be at least 1");
      if (CONT_WORDS * 4 > (1 << 20))
         $error("cdma_channel: container too large");
   end

   cdma_state_e          state_q, state_d;
   logic [31:0]          data_q;
   logic [WIDX_W-1:0]    word_idx;
   logic                 word_last;
   logic                 word_inc;
   logic [RIDX_W-1:0]    ring_idx;
   logic                 ring_last;
   logic                 slot;
   logic                 slot_last;
   logic                 cont_done;
   logic [PADDR_W-1:0]   stat_addr;
   logic [PADDR_W-1:0]   buf_base;
   logic [PADDR_W-1:0]   word_addr;
   logic                 slot_ready;
   logic                 stat_ok;
   logic [31:0]          stat_new;

   // word, ring and slot position counters
   cdma_modcnt #(.MOD(CONT_WORDS), .W(WIDX_W)) u_word (
      .clk(clk), .rst_n(rst_n), .inc_i(word_inc),
      .val_o(word_idx), .last_o(word_last)
   );

   cdma_modcnt #(.MOD(RING_DEPTH), .W(RIDX_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .inc_i(cont_done),
      .val_o(ring_idx), .last_o(ring_last)
   );

   cdma_modcnt #(.MOD(2), .W(1)) u_slot (
      .clk(clk), .rst_n(rst_n), .inc_i(cont_done),
      .val_o(slot), .last_o(slot_last)
   );

   cdma_desc_sel #(.RING_DEPTH(RING_DEPTH), .RIDX_W(RIDX_W)) u_desc (
      .ring_i(desc_ring_i), .idx_i(ring_idx),
      .stat_addr_o(stat_addr), .buf_addr_o(buf_base)
   );

   assign word_addr = buf_base + PADDR_W'({word_idx, 2'b00});
   assign cont_done = (state_q == ST_DONE);

   // direction-specific readiness, status test and slot flag update
   generate
      if (IS_RX) begin : g_rx
         assign slot_ready = hw_full_i[slot];
         assign stat_ok    = (mem_rdata_i == 32'd0);
         assign stat_new   = 32'd1;
         assign hw_clr_o   = cont_done ? (2'b01 << slot) : 2'b00;
         assign hw_set_o   = 2'b00;
      end else begin : g_tx
         assign slot_ready = !hw_full_i[slot];
         assign stat_ok    = (mem_rdata_i != 32'd0);
         assign stat_new   = 32'd0;
         assign hw_set_o   = cont_done ? (2'b01 << slot) : 2'b00;
         assign hw_clr_o   = 2'b00;
      end
   endgenerate

   always_comb begin
      state_d  = state_q;
      word_inc = 1'b0;
      unique case (state_q)
         ST_IDLE:  if (run_i && slot_ready) state_d = ST_POLL;
         ST_POLL:  if (mem_gnt_i) state_d = ST_PWAIT;
         ST_PWAIT: begin
            if (mem_rvalid_i) begin
               if (!stat_ok)   state_d = ST_IDLE;
               else if (IS_RX) state_d = ST_BRD;
               else            state_d = ST_MRD;
            end
         end
         ST_BRD:   state_d = ST_BCAP;
         ST_BCAP:  state_d = ST_MWR;
         ST_MWR: begin
            if (mem_gnt_i) begin
               word_inc = 1'b1;
               state_d  = word_last ? ST_STAT : ST_BRD;
            end
         end
         ST_MRD:   if (mem_gnt_i) state_d = ST_MWAIT;
         ST_MWAIT: begin
            if (mem_rvalid_i) begin
               word_inc = 1'b1;
               state_d  = word_last ? ST_STAT : ST_MRD;
            end
         end
         ST_STAT:  if (mem_gnt_i) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_BCAP) data_q <= buf_rdata_i;
      end
   end

   always_comb begin
      mem_req_o  = 1'b0;
      mem_we_o   = 1'b0;
      mem_addr_o = stat_addr;
      case (state_q)
         ST_POLL: mem_req_o = 1'b1;
         ST_STAT: begin
            mem_req_o = 1'b1;
            mem_we_o  = 1'b1;
         end
         ST_MWR: begin
            mem_req_o  = 1'b1;
            mem_we_o   = 1'b1;
            mem_addr_o = word_addr;
         end
         ST_MRD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = word_addr;
         end
         default: ;
      endcase
   end

   assign mem_wdata_o = (state_q == ST_STAT) ? stat_new : data_q;
   assign buf_slot_o  = slot;
   assign buf_word_o  = word_idx;
   assign buf_rd_o    = (state_q == ST_BRD);
   assign buf_wr_o    = (state_q == ST_MWAIT) && mem_rvalid_i;
   assign buf_wdata_o = mem_rdata_i;
   assign event_o     = cont_done;

endmodule

// File: rtl/cdma_channel_chk.sv
module cdma_channel_chk #(
   parameter bit IS_RX = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        mem_req_o,
   input logic        mem_we_o,
   input logic [43:0] mem_addr_o,
   input logic [31:0] mem_wdata_o,
   input logic        mem_gnt_i,
   input logic [1:0]  hw_set_o,
   input logic [1:0]  hw_clr_o,
   input logic        buf_rd_o,
   input logic        buf_wr_o,
   input logic        event_o
);

   logic seen_q;
   logic last_slot_q;
   logic pulse_slot;

   assign pulse_slot = (hw_set_o[1] | hw_clr_o[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q      <= 1'b0;
         last_slot_q <= 1'b0;
      end else if (event_o) begin
         seen_q      <= 1'b1;
         last_slot_q <= pulse_slot;
      end
   end

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));

   assert_event_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |=> !event_o);

   assert_event_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      event_o == ($countones({hw_set_o, hw_clr_o}) == 1));

   assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> mem_addr_o[1:0] == 2'b00);

   assert_slot_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      event_o && seen_q |-> pulse_slot != last_slot_q);

   assert_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      IS_RX |-> hw_set_o == 2'b00 && !buf_wr_o);

   assert_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !IS_RX |-> hw_clr_o == 2'b00 && !buf_rd_o);

   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> !mem_req_o);

endmodule

bind cdma_channel cdma_channel_chk #(.IS_RX(IS_RX)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
   .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
   .hw_set_o(hw_set_o), .hw_clr_o(hw_clr_o),
   .buf_rd_o(buf_rd_o), .buf_wr_o(buf_wr_o), .event_o(event_o)
);

// File: tb/tb_cdma_channel.sv
module tb_cdma_model #(
   parameter logic [11:0] EXT = 12'h000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mem_req,
   input  logic        mem_we,
   input  logic [43:0] mem_addr,
   input  logic [31:0] mem_wdata,
   output logic        mem_gnt,
   output logic        mem_rvalid,
   output logic [31:0] mem_rdata,
   input  logic        buf_slot,
   input  logic [2:0]  buf_word,
   input  logic        buf_rd,
   input  logic        buf_wr,
   input  logic [31:0] buf_wdata,
   output logic [31:0] buf_rdata,
   input  logic [1:0]  hw_set,
   input  logic [1:0]  hw_clr,
   output logic [1:0]  hw_full,
   input  logic        ev,
   input  logic        poke_we,
   input  logic [9:0]  poke_idx,
   input  logic [31:0] poke_data,
   input  logic        hpoke_we,
   input  logic [3:0]  hpoke_idx,
   input  logic [31:0] hpoke_data,
   input  logic [1:0]  sw_set,
   input  logic [1:0]  sw_clr
);
   logic [31:0] mem [0:1023];
   logic [31:0] hwbuf [0:15];
   logic [7:0]  lfsr;
   int          ev_cnt, ngnt, nbad;

   assign mem_gnt = mem_req && (lfsr[1:0] != 2'b00);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= '0;
         for (int i = 0; i < 16; i++) hwbuf[i] <= '0;
         lfsr <= 8'h5A; mem_rvalid <= 1'b0; mem_rdata <= '0; buf_rdata <= '0;
         hw_full <= 2'b00; ev_cnt <= 0; ngnt <= 0; nbad <= 0;
      end else begin
         lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         mem_rvalid <= 1'b0;
         if (mem_req && mem_gnt) begin
            ngnt <= ngnt + 1;
            if (mem_addr[43:32] != EXT || mem_addr[31:12] != 20'd0) nbad <= nbad + 1;
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= mem[mem_addr[11:2]];
            end
         end
         if (poke_we) mem[poke_idx] <= poke_data;
         if (buf_rd) buf_rdata <= hwbuf[{buf_slot, buf_word}];
         if (buf_wr) hwbuf[{buf_slot, buf_word}] <= buf_wdata;
         if (hpoke_we) hwbuf[hpoke_idx] <= hpoke_data;
         hw_full <= (hw_full | hw_set | sw_set) & ~(hw_clr | sw_clr);
         if (ev) ev_cnt <= ev_cnt + 1;
      end
   end
endmodule

module tb_cdma_channel;
   localparam int CW = 8;
   localparam int RD = 3;
   localparam logic [11:0] RX_EXT = 12'hA5C;
   localparam logic [11:0] TX_EXT = 12'h3B1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0;

   function automatic logic [RD*64-1:0] make_ring(input logic [11:0] ext);
      logic [RD*64-1:0] r;
      for (int i = 0; i < RD; i++)
         r[64*i +: 64] = {ext, 26'(16 + i), 26'(i)};
      return r;
   endfunction

   function automatic int stat_idx(input int r); return 16 * r; endfunction
   function automatic int buf_idx(input int r, input int w); return 256 + 16 * r + w; endfunction
   function automatic logic [31:0] pat(input int n, input int w);
      return 32'hC0DE_0000 ^ (n << 8) ^ w;
   endfunction

   // RX side signals
   logic        rx_run = 1'b0;
   logic        rx_req, rx_we, rx_gnt, rx_rv, rx_slot, rx_rd, rx_wr, rx_ev;
   logic [43:0] rx_addr;
   logic [31:0] rx_wd, rx_rdat, rx_bwd, rx_brd;
   logic [2:0]  rx_word;
   logic [1:0]  rx_set, rx_clr, rx_full;
   logic        rx_pwe = 0, rx_hwe = 0;
   logic [9:0]  rx_pidx = 0;
   logic [3:0]  rx_hidx = 0;
   logic [31:0] rx_pdat = 0, rx_hdat = 0;
   logic [1:0]  rx_sset = 0, rx_sclr = 0;

   // TX side signals
   logic        tx_run = 1'b0;
   logic        tx_req, tx_we, tx_gnt, tx_rv, tx_slot, tx_rd, tx_wr, tx_ev;
   logic [43:0] tx_addr;
   logic [31:0] tx_wd, tx_rdat, tx_bwd, tx_brd;
   logic [2:0]  tx_word;
   logic [1:0]  tx_set, tx_clr, tx_full;
   logic        tx_pwe = 0, tx_hwe = 0;
   logic [9:0]  tx_pidx = 0;
   logic [3:0]  tx_hidx = 0;
   logic [31:0] tx_pdat = 0, tx_hdat = 0;
   logic [1:0]  tx_sset = 0, tx_sclr = 0;

   cdma_channel #(.IS_RX(1'b1), .CONT_WORDS(CW), .RING_DEPTH(RD)) dut (
      .clk(clk), .rst_n(rst_n), .run_i(rx_run), .desc_ring_i(make_ring(RX_EXT)),
      .mem_req_o(rx_req), .mem_we_o(rx_we), .mem_addr_o(rx_addr), .mem_wdata_o(rx_wd),
      .mem_gnt_i(rx_gnt), .mem_rvalid_i(rx_rv), .mem_rdata_i(rx_rdat),
      .hw_full_i(rx_full), .hw_set_o(rx_set), .hw_clr_o(rx_clr),
      .buf_slot_o(rx_slot), .buf_word_o(rx_word), .buf_rd_o(rx_rd), .buf_wr_o(rx_wr),
      .buf_wdata_o(rx_bwd), .buf_rdata_i(rx_brd), .event_o(rx_ev));

   tb_cdma_model #(.EXT(RX_EXT)) rxm (
      .clk(clk), .rst_n(rst_n), .mem_req(rx_req), .mem_we(rx_we), .mem_addr(rx_addr),
      .mem_wdata(rx_wd), .mem_gnt(rx_gnt), .mem_rvalid(rx_rv), .mem_rdata(rx_rdat),
      .buf_slot(rx_slot), .buf_word(rx_word), .buf_rd(rx_rd), .buf_wr(rx_wr),
      .buf_wdata(rx_bwd), .buf_rdata(rx_brd), .hw_set(rx_set), .hw_clr(rx_clr),
      .hw_full(rx_full), .ev(rx_ev), .poke_we(rx_pwe), .poke_idx(rx_pidx),
      .poke_data(rx_pdat), .hpoke_we(rx_hwe), .hpoke_idx(rx_hidx), .hpoke_data(rx_hdat),
      .sw_set(rx_sset), .sw_clr(rx_sclr));

   cdma_channel #(.IS_RX(1'b0), .CONT_WORDS(CW), .RING_DEPTH(RD)) dut_tx (
      .clk(clk), .rst_n(rst_n), .run_i(tx_run), .desc_ring_i(make_ring(TX_EXT)),
      .mem_req_o(tx_req), .mem_we_o(tx_we), .mem_addr_o(tx_addr), .mem_wdata_o(tx_wd),
      .mem_gnt_i(tx_gnt), .mem_rvalid_i(tx_rv), .mem_rdata_i(tx_rdat),
      .hw_full_i(tx_full), .hw_set_o(tx_set), .hw_clr_o(tx_clr),
      .buf_slot_o(tx_slot), .buf_word_o(tx_word), .buf_rd_o(tx_rd), .buf_wr_o(tx_wr),
      .buf_wdata_o(tx_bwd), .buf_rdata_i(tx_brd), .event_o(tx_ev));

   tb_cdma_model #(.EXT(TX_EXT)) txm (
      .clk(clk), .rst_n(rst_n), .mem_req(tx_req), .mem_we(tx_we), .mem_addr(tx_addr),
      .mem_wdata(tx_wd), .mem_gnt(tx_gnt), .mem_rvalid(tx_rv), .mem_rdata(tx_rdat),
      .buf_slot(tx_slot), .buf_word(tx_word), .buf_rd(tx_rd), .buf_wr(tx_wr),
      .buf_wdata(tx_bwd), .buf_rdata(tx_brd), .hw_set(tx_set), .hw_clr(tx_clr),
      .hw_full(tx_full), .ev(tx_ev), .poke_we(tx_pwe), .poke_idx(tx_pidx),
      .poke_data(tx_pdat), .hpoke_we(tx_hwe), .hpoke_idx(tx_hidx), .hpoke_data(tx_hdat),
      .sw_set(tx_sset), .sw_clr(tx_sclr));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic mem_poke(input bit tx, input int idx, input logic [31:0] d);
      if (tx) begin tx_pwe = 1; tx_pidx = 10'(idx); tx_pdat = d; end
      else    begin rx_pwe = 1; rx_pidx = 10'(idx); rx_pdat = d; end
      @(negedge clk);
      rx_pwe = 0; tx_pwe = 0;
   endtask

   task automatic hw_poke(input int idx, input logic [31:0] d);
      rx_hwe = 1; rx_hidx = 4'(idx); rx_hdat = d;
      @(negedge clk);
      rx_hwe = 0;
   endtask

   task automatic flag(input bit tx, input bit set, input int s);
      if (tx) begin if (set) tx_sset[s] = 1'b1; else tx_sclr[s] = 1'b1; end
      else    begin if (set) rx_sset[s] = 1'b1; else rx_sclr[s] = 1'b1; end
      @(negedge clk);
      rx_sset = 0; rx_sclr = 0; tx_sset = 0; tx_sclr = 0;
   endtask

   task automatic wait_ev(input bit tx, input int n, input string req);
      int k = 0;
      while ((tx ? txm.ev_cnt : rxm.ev_cnt) < n && k < 5000) begin
         @(negedge clk); k++;
      end
      chk(req, 32'(tx ? txm.ev_cnt : rxm.ev_cnt), 32'(n));
   endtask

   task automatic fill_slot(input int s, input int n);
      for (int w = 0; w < CW; w++) hw_poke(s * 8 + w, pat(n, w));
   endtask

   task automatic check_rx_cont(input int r, input int n, input string req);
      for (int w = 0; w < CW; w++) chk(req, rxm.mem[buf_idx(r, w)], pat(n, w));
      chk(req, rxm.mem[stat_idx(r)], 32'd1);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin @(posedge clk); cyc++; end
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 remaining cycles", cyc);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      chk("R1 req in reset", {rx_req, tx_req}, 0);
      chk("R1 pulses in reset", {rx_set, rx_clr, tx_set, tx_clr, rx_ev, tx_ev}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 slot after reset", {rx_slot, tx_slot}, 0);

      // R3: slot full but run low, no memory traffic
      fill_slot(0, 0);
      flag(0, 1, 0);
      repeat (60) @(negedge clk);
      chk("R3 no grants while stopped", rxm.ngnt, 0);
      chk("R3 no event while stopped", rxm.ev_cnt, 0);

      // R5 R2 R9: first RX container into ring entry 0
      rx_run = 1'b1;
      wait_ev(0, 1, "R5 first rx container");
      check_rx_cont(0, 0, "R5 R2 ring0 data");
      chk("R5 slot0 cleared", rx_full, 2'b00);
      chk("R9 ring1 untouched", rxm.mem[buf_idx(1, 0)], 0);

      // R8: second container from slot 1 to ring 1
      fill_slot(1, 1);
      flag(0, 1, 1);
      wait_ev(0, 2, "R8 second rx container");
      check_rx_cont(1, 1, "R8 ring1 from slot1");

      // R4: ring 2 busy, channel must not move data
      mem_poke(0, stat_idx(2), 32'd7);
      fill_slot(0, 2);
      flag(0, 1, 0);
      repeat (200) @(negedge clk);
      chk("R4 no event while busy", rxm.ev_cnt, 2);
      chk("R4 buffer untouched", rxm.mem[buf_idx(2, 0)], 0);
      chk("R4 slot stays full", rx_full, 2'b01);
      chk("R4 status unchanged", rxm.mem[stat_idx(2)], 7);
      mem_poke(0, stat_idx(2), 32'd0);
      wait_ev(0, 3, "R4 released");
      check_rx_cont(2, 2, "R4 ring2 data");

      // R9: wrap to ring 0 after it is consumed by software
      mem_poke(0, stat_idx(0), 32'd0);
      for (int w = 0; w < CW; w++) mem_poke(0, buf_idx(0, w), 0);
      fill_slot(1, 3);
      flag(0, 1, 1);
      wait_ev(0, 4, "R9 wrap");
      check_rx_cont(0, 3, "R9 ring0 after wrap");
      chk("R2 rx address extension", rxm.nbad, 0);
      chk("R10 rx event count", rxm.ev_cnt, 4);

      // TX direction
      for (int w = 0; w < CW; w++) mem_poke(1, buf_idx(0, w), pat(10, w));
      mem_poke(1, stat_idx(0), 32'd1);
      tx_run = 1'b1;
      wait_ev(1, 1, "R6 first tx container");
      for (int w = 0; w < CW; w++) chk("R6 slot0 data", txm.hwbuf[w], pat(10, w));
      chk("R6 status cleared", txm.mem[stat_idx(0)], 0);
      chk("R6 slot0 marked full", tx_full, 2'b01);

      // R7: ring 1 empty, wait
      repeat (200) @(negedge clk);
      chk("R7 no event while empty", txm.ev_cnt, 1);
      chk("R7 slot1 stays empty", tx_full, 2'b01);
      chk("R7 slot1 untouched", txm.hwbuf[8], 0);
      for (int w = 0; w < CW; w++) mem_poke(1, buf_idx(1, w), pat(11, w));
      mem_poke(1, stat_idx(1), 32'd5);
      wait_ev(1, 2, "R7 released");
      for (int w = 0; w < CW; w++) chk("R8 slot1 data", txm.hwbuf[8 + w], pat(11, w));

      // R6: slot 0 still full, ring 2 waits until the slot is drained
      for (int w = 0; w < CW; w++) mem_poke(1, buf_idx(2, w), pat(12, w));
      mem_poke(1, stat_idx(2), 32'd9);
      repeat (100) @(negedge clk);
      chk("R6 wait for empty slot", txm.ev_cnt, 2);
      flag(1, 0, 0);
      wait_ev(1, 3, "R6 third tx container");
      for (int w = 0; w < CW; w++) chk("R8 slot0 reused", txm.hwbuf[w], pat(12, w));
      chk("R2 tx address extension", txm.nbad, 0);

      finish_run();
   end
endmodule